// File: doc/BRIEF.md
# Serial Channel Interrupt Status Vector

This block holds the interrupt state for one serial channel. It tracks three interrupt sources: transmit buffer empty, receive character available and receive special condition. It drives one registered interrupt request line. It also provides a vector register that software reads to find out which source to service. The vector carries a programmable base with a two-bit source code inserted into it. On every read, that code names the highest-priority source that is still pending.

The transmitter and receiver supply single-cycle strobes. Software writes a command byte, a master enable bit and the vector base, and it issues a read strobe to sample the vector. A service routine reads the vector, services the source it names, and clears that source. It then reads the vector again and repeats until the code shows no source pending. No new acknowledge cycle from the external interrupt controller is needed between these reads. Transmit-empty interrupts are armed only by a character write. After the transmit source is cleared by command, the buffer emptying again raises nothing until software writes another character.

Top module: `sio_irq_vec`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0x00 and `err_o` is 0.
- R2: A `tx_load_i` strobe with no `tx_wr_i` since reset leaves the transmit source idle. The next vector read shows code 00 in bits 5:4.
- R3: A `tx_wr_i` strobe followed by a `tx_load_i` strobe makes the transmit source pending. With nothing else pending, the next vector read shows code 01.
- R4: Command byte 0x28 clears the transmit source. Further `tx_load_i` strobes raise nothing until another `tx_wr_i`.
- R5: A `rx_avail_i` strobe makes the receive source pending, shown as code 10. A `rx_rd_i` strobe clears it.
- R6: The error strobes latch sticky flags in `err_o`: bit 0 is framing, bit 1 is overrun and bit 2 is parity. Any flag set makes the special source pending, shown as code 11.
- R7: Command byte 0x30 clears every `err_o` flag, which also clears the special source.
- R8: The priority order is special (11), then receive (10), then transmit (01). Each vector read reports the highest source pending at the read. After that source is cleared, the next read reports the next one down.
- R9: Vector bits 5:4 hold the source code. Every other vector bit equals the corresponding bit of the base written through `base_we_i`.
- R10: `irq_o` equals the AND of the master enable and the OR of the pending sources, delayed by one register stage.
- R11: Writing the master enable to 0 and then to 1 while a source is pending drops `irq_o` and then raises it again.
- R12: Command bytes other than 0x28 and 0x30 change no pending source and no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_i | input | 1 | Software wrote a character to the transmit buffer |
| tx_load_i | input | 1 | Transmit buffer moved into the shift register |
| rx_avail_i | input | 1 | Receive character became available |
| rx_rd_i | input | 1 | Receive data register read |
| err_frame_i | input | 1 | Framing error strobe |
| err_overrun_i | input | 1 | Receiver overrun strobe |
| err_parity_i | input | 1 | Parity error strobe |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_i | input | 8 | Command byte |
| mie_we_i | input | 1 | Master enable write strobe |
| mie_i | input | 1 | Master enable value |
| base_we_i | input | 1 | Vector base write strobe |
| base_i | input | 8 | Vector base value |
| vec_rd_i | input | 1 | Vector read strobe |
| irq_o | output | 1 | Registered interrupt request |
| vec_o | output | 8 | Vector captured at the last read |
| err_o | output | 3 | Latched error flags |

## Verification
The assertions assume two things about the inputs. A character write never falls in the same cycle as a buffer load or a transmit clear command. An error strobe never coincides with the error clear command. Under these conditions each clear is seen to act on the cycle after its command. The stimulus drives one strobe per cycle and always finishes a setup sequence before it issues the command under test, so those collisions never occur. The command sweep covers all 256 byte values against a fully loaded pending state.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int NSRC   = 3;
    localparam int ERR_W  = 3;
    localparam int SRC_TX = 0;
    localparam int SRC_RX = 1;
    localparam int SRC_SP = 2;

    typedef enum logic [1:0] {
        CODE_NONE = 2'b00,
        CODE_TXE  = 2'b01,
        CODE_RXA  = 2'b10,
        CODE_SPC  = 2'b11
    } src_code_e;

    typedef struct packed {
        logic             tx_armed;
        logic             tx_ip;
        logic             rx_ip;
        logic [ERR_W-1:0] err;
    } pend_st_t;

endpackage

// File: rtl/sio_irq_pend.sv
module sio_irq_pend
    import sio_irq_pkg::*;
#(
    parameter int                CMD_W       = 8,
    parameter logic [CMD_W-1:0]  CMD_CLR_TX  = 8'h28,
    parameter logic [CMD_W-1:0]  CMD_CLR_ERR = 8'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wr_i,
    input  logic             tx_load_i,
    input  logic             rx_avail_i,
    input  logic             rx_rd_i,
    input  logic [ERR_W-1:0] err_set_i,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic [NSRC-1:0]  pend_o,
    output logic [ERR_W-1:0] err_o
);

    pend_st_t         st_d, st_q;
    logic             clr_tx;
    logic             clr_err;
    logic [ERR_W-1:0] err_nxt;

    assign clr_tx  = cmd_we_i && (cmd_i == CMD_CLR_TX);
    assign clr_err = cmd_we_i && (cmd_i == CMD_CLR_ERR);

    // one sticky flag per error kind; a new strobe wins over the clear
    for (genvar g = 0; g < ERR_W; g++) begin : g_err
        assign err_nxt[g] = err_set_i[g] | (st_q.err[g] & ~clr_err);
    end

    always_comb begin
        st_d = st_q;
        if (tx_wr_i) begin
            st_d.tx_armed = 1'b1;
            st_d.tx_ip    = 1'b0;
        end else if (tx_load_i && st_q.tx_armed) begin
            st_d.tx_ip    = 1'b1;
            st_d.tx_armed = 1'b0;
        end
        if (clr_tx) begin
            st_d.tx_ip = 1'b0;
        end
        if (rx_avail_i) begin
            st_d.rx_ip = 1'b1;
        end else if (rx_rd_i) begin
            st_d.rx_ip = 1'b0;
        end
        st_d.err = err_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o[SRC_TX] = st_q.tx_ip;
    assign pend_o[SRC_RX] = st_q.rx_ip;
    assign pend_o[SRC_SP] = |st_q.err;
    assign err_o          = st_q.err;

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
    parameter int NSRC   = 3,
    localparam int CODE_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]   pend_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);

    // higher index means higher priority; code is index plus one, zero = none
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i]) begin
                code_o = CODE_W'(i + 1);
            end
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/sio_irq_req.sv
module sio_irq_req #(
    parameter int VEC_W    = 8,
    parameter int CODE_LSB = 4,
    parameter int CODE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mie_we_i,
    input  logic              mie_i,
    input  logic              base_we_i,
    input  logic [VEC_W-1:0]  base_i,
    input  logic              vec_rd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              any_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              mie_o
);

    typedef struct packed {
        logic             mie;
        logic             irq;
        logic [VEC_W-1:0] base;
        logic [VEC_W-1:0] vec;
    } req_st_t;

    req_st_t          st_d, st_q;
    logic [VEC_W-1:0] vec_live;

    // splice the source code into the base
    for (genvar b = 0; b < VEC_W; b++) begin : g_vec
        if (b >= CODE_LSB && b < CODE_LSB + CODE_W) begin : g_code
            assign vec_live[b] = code_i[b - CODE_LSB];
        end else begin : g_base
            assign vec_live[b] = st_q.base[b];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = st_q.mie & any_i;
        if (mie_we_i) begin
            st_d.mie = mie_i;
        end
        if (base_we_i) begin
            st_d.base = base_i;
        end
        if (vec_rd_i) begin
            st_d.vec = vec_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
    assign vec_o = st_q.vec;
    assign mie_o = st_q.mie;

endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec
    import sio_irq_pkg::*;
#(
    parameter int               CMD_W       = 8,
    parameter int               VEC_W       = 8,
    parameter int               CODE_LSB    = 4,
    parameter logic [CMD_W-1:0] CMD_CLR_TX  = 8'h28,
    parameter logic [CMD_W-1:0] CMD_CLR_ERR = 8'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wr_i,
    input  logic             tx_load_i,
    input  logic             rx_avail_i,
    input  logic             rx_rd_i,
    input  logic             err_frame_i,
    input  logic             err_overrun_i,
    input  logic             err_parity_i,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             mie_we_i,
    input  logic             mie_i,
    input  logic             base_we_i,
    input  logic [VEC_W-1:0] base_i,
    input  logic             vec_rd_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [ERR_W-1:0] err_o
);

    localparam int CODE_W = $clog2(NSRC + 1);

    logic [ERR_W-1:0]  err_set;
    logic [NSRC-1:0]   pend;
    logic [CODE_W-1:0] code;
    logic              any_pend;
    logic              mie_q;

    assign err_set = {err_parity_i, err_overrun_i, err_frame_i};

    sio_irq_pend #(
        .CMD_W      (CMD_W),
        .CMD_CLR_TX (CMD_CLR_TX),
        .CMD_CLR_ERR(CMD_CLR_ERR)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_wr_i   (tx_wr_i),
        .tx_load_i (tx_load_i),
        .rx_avail_i(rx_avail_i),
        .rx_rd_i   (rx_rd_i),
        .err_set_i (err_set),
        .cmd_we_i  (cmd_we_i),
        .cmd_i     (cmd_i),
        .pend_o    (pend),
        .err_o     (err_o)
    );

    sio_irq_prio #(
        .NSRC(NSRC)
    ) u_prio (
        .pend_i(pend),
        .code_o(code),
        .any_o (any_pend)
    );

    sio_irq_req #(
        .VEC_W   (VEC_W),
        .CODE_LSB(CODE_LSB),
        .CODE_W  (CODE_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .mie_we_i (mie_we_i),
        .mie_i    (mie_i),
        .base_we_i(base_we_i),
        .base_i   (base_i),
        .vec_rd_i (vec_rd_i),
        .code_i   (code),
        .any_i    (any_pend),
        .irq_o    (irq_o),
        .vec_o    (vec_o),
        .mie_o    (mie_q)
    );

endmodule

// File: rtl/sio_irq_vec_chk.sv
module sio_irq_vec_chk #(
    parameter int               CMD_W       = 8,
    parameter int               VEC_W       = 8,
    parameter int               CODE_LSB    = 4,
    parameter logic [CMD_W-1:0] CMD_CLR_TX  = 8'h28,
    parameter logic [CMD_W-1:0] CMD_CLR_ERR = 8'h30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_wr_i,
    input logic             tx_load_i,
    input logic             rx_avail_i,
    input logic             rx_rd_i,
    input logic [2:0]       err_set,
    input logic             cmd_we_i,
    input logic [CMD_W-1:0] cmd_i,
    input logic             vec_rd_i,
    input logic [2:0]       pend,
    input logic             mie_q,
    input logic             irq_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [2:0]       err_o
);

    // R10
    irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(mie_q && (pend != 3'b000)));

    // R2
    tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> $past(tx_load_i));

    // R4
    tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && cmd_i == CMD_CLR_TX && !tx_wr_i && !tx_load_i) |=> !pend[0]);

    // R5
    rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_i && !rx_avail_i) |=> !pend[1]);

    // R7
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && cmd_i == CMD_CLR_ERR && err_set == 3'b000) |=> (err_o == 3'b000));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(err_o) & ~err_o) != 3'b000) |-> ($past(cmd_we_i) && $past(cmd_i) == CMD_CLR_ERR));

    // R8
    vec_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vec_rd_i) && $past(pend[2])) |-> (vec_o[CODE_LSB+1:CODE_LSB] == 2'b11));

endmodule

bind sio_irq_vec sio_irq_vec_chk #(
    .CMD_W      (CMD_W),
    .VEC_W      (VEC_W),
    .CODE_LSB   (CODE_LSB),
    .CMD_CLR_TX (CMD_CLR_TX),
    .CMD_CLR_ERR(CMD_CLR_ERR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_wr_i   (tx_wr_i),
    .tx_load_i (tx_load_i),
    .rx_avail_i(rx_avail_i),
    .rx_rd_i   (rx_rd_i),
    .err_set   (err_set),
    .cmd_we_i  (cmd_we_i),
    .cmd_i     (cmd_i),
    .vec_rd_i  (vec_rd_i),
    .pend      (pend),
    .mie_q     (mie_q),
    .irq_o     (irq_o),
    .vec_o     (vec_o),
    .err_o     (err_o)
);

// File: tb/sio_irq_vec_bench.sv
module sio_irq_vec_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_wr_i = 1'b0, tx_load_i = 1'b0;
    logic       rx_avail_i = 1'b0, rx_rd_i = 1'b0;
    logic       err_frame_i = 1'b0, err_overrun_i = 1'b0, err_parity_i = 1'b0;
    logic       cmd_we_i = 1'b0;
    logic [7:0] cmd_i = 8'h00;
    logic       mie_we_i = 1'b0, mie_i = 1'b0;
    logic       base_we_i = 1'b0;
    logic [7:0] base_i = 8'h00;
    logic       vec_rd_i = 1'b0;
    logic       irq_o;
    logic [7:0] vec_o;
    logic [2:0] err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sio_irq_vec u_sio_irq_vec (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_i(tx_wr_i), .tx_load_i(tx_load_i),
        .rx_avail_i(rx_avail_i), .rx_rd_i(rx_rd_i),
        .err_frame_i(err_frame_i), .err_overrun_i(err_overrun_i),
        .err_parity_i(err_parity_i),
        .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
        .mie_we_i(mie_we_i), .mie_i(mie_i),
        .base_we_i(base_we_i), .base_i(base_i),
        .vec_rd_i(vec_rd_i),
        .irq_o(irq_o), .vec_o(vec_o), .err_o(err_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic p_txwr();   tx_wr_i = 1'b1;    step(); tx_wr_i = 1'b0;    endtask
    task automatic p_txld();   tx_load_i = 1'b1;  step(); tx_load_i = 1'b0;  endtask
    task automatic p_rxav();   rx_avail_i = 1'b1; step(); rx_avail_i = 1'b0; endtask
    task automatic p_rxrd();   rx_rd_i = 1'b1;    step(); rx_rd_i = 1'b0;    endtask

    task automatic p_err(input logic [2:0] e);
        {err_parity_i, err_overrun_i, err_frame_i} = e;
        step();
        {err_parity_i, err_overrun_i, err_frame_i} = 3'b000;
    endtask

    task automatic p_cmd(input logic [7:0] c);
        cmd_we_i = 1'b1; cmd_i = c; step(); cmd_we_i = 1'b0; cmd_i = 8'h00;
    endtask

    task automatic p_mie(input logic v);
        mie_we_i = 1'b1; mie_i = v; step(); mie_we_i = 1'b0;
    endtask

    task automatic p_base(input logic [7:0] b);
        base_we_i = 1'b1; base_i = b; step(); base_we_i = 1'b0;
    endtask

    // returns the two-bit source code from a fresh vector read
    task automatic rd_code(output int code);
        vec_rd_i = 1'b1; step(); vec_rd_i = 1'b0;
        code = int'(vec_o[5:4]);
    endtask

    task automatic clear_all();
        p_cmd(8'h28); p_cmd(8'h30); p_rxrd();
    endtask

    task automatic load_tx();
        p_txwr(); p_txld();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int code;
        int exp;
        step(); step();
        // R1 reset state
        check("R1 irq", int'(irq_o), 0);
        check("R1 vec", int'(vec_o), 0);
        check("R1 err", int'(err_o), 0);
        rst_n = 1'b1;
        step();

        // R2 load with no write since reset
        p_txld(); step();
        rd_code(code);
        check("R2 no arm", code, 0);

        // R3 / R4 write, load, clear, reload without write
        load_tx();
        rd_code(code);
        check("R3 tx code", code, 1);
        p_cmd(8'h28);
        rd_code(code);
        check("R4 cleared", code, 0);
        p_txld(); p_txld();
        rd_code(code);
        check("R4 no rearm", code, 0);

        // R5 receive set and clear
        p_rxav();
        rd_code(code);
        check("R5 rx code", code, 2);
        p_rxrd();
        rd_code(code);
        check("R5 rx clr", code, 0);

        // R8 / R10 sweep: every source mix, both enable values
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 8; s++) begin
                clear_all();
                p_mie(m[0]);
                if (s[0]) load_tx();
                if (s[1]) p_rxav();
                if (s[2]) p_err(3'b001);
                step(); step();
                check("R10 irq", int'(irq_o), (m == 1 && s != 0) ? 1 : 0);
                exp = s[2] ? 3 : (s[1] ? 2 : (s[0] ? 1 : 0));
                // R8 walk down the pending list one clear at a time
                for (int k = 0; k < 4; k++) begin
                    rd_code(code);
                    check("R8 prio", code, exp);
                    if (code == 3) p_cmd(8'h30);
                    else if (code == 2) p_rxrd();
                    else if (code == 1) p_cmd(8'h28);
                    if (exp == 3) exp = s[1] ? 2 : (s[0] ? 1 : 0);
                    else if (exp == 2) exp = s[0] ? 1 : 0;
                    else exp = 0;
                end
            end
        end
        p_mie(1'b0);

        // R6 / R7 every error flag combination
        for (int e = 1; e < 8; e++) begin
            clear_all();
            p_err(e[2:0]);
            check("R6 err", int'(err_o), e);
            rd_code(code);
            check("R6 spc code", code, 3);
            p_cmd(8'h30);
            check("R7 err clr", int'(err_o), 0);
            rd_code(code);
            check("R7 spc clr", code, 0);
        end

        // R9 base bits around the code field
        clear_all();
        p_rxav();
        for (int b = 0; b < 256; b += 17) begin
            p_base(8'(b));
            vec_rd_i = 1'b1; step(); vec_rd_i = 1'b0;
            check("R9 vec", int'(vec_o), (b & 8'hCF) | 8'h20);
        end
        p_base(8'h00);

        // R11 enable toggle re-edges the request
        p_mie(1'b1); step();
        check("R11 irq on", int'(irq_o), 1);
        p_mie(1'b0); step();
        check("R11 irq drop", int'(irq_o), 0);
        p_mie(1'b1); step();
        check("R11 irq back", int'(irq_o), 1);
        p_mie(1'b0);

        // R12 every command byte against a full pending set
        for (int c = 0; c < 256; c++) begin
            clear_all();
            load_tx(); p_rxav(); p_err(3'b111);
            p_cmd(8'(c));
            check("R12 err", int'(err_o), (c == 8'h30) ? 0 : 7);
            p_cmd(8'h30); p_rxrd();
            rd_code(code);
            check("R12 tx", code, (c == 8'h28) ? 0 : 1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule